// File: doc/BRIEF.md
# Indirect Codec Control Register Bank

This block is the host-facing control register bank of an audio codec. The host sees only two byte-wide locations. The first is an index port that selects one of up to 32 internal control registers. The second is a data port that reads or writes the selected register. The bank also owns three pieces of housekeeping that host software polls through those two ports. The first is a busy flag that covers power-on initialization. The second is a mode switch that widens the register space from 16 to 32 entries. The third is a calibration sequence that starts when the host leaves mode-change state.

Several registers are not plain storage. One volume register has a read-only bit. The miscellaneous register carries a fixed revision code around its single writable mode bit. The test register reports calibration progress in one of its bits. In the 16-register legacy mode, the upper half of the index space folds back onto the lower half. This lets host software probe which generation of the register set is present.

Access is a plain strobe interface. The host raises `bus_wr` or `bus_rd` for one cycle with `bus_sel` choosing the port. A read answers on the next cycle with `bus_rvalid`, and there is no back-pressure. A read returns the state as it stood before any write in the same cycle.

Top module: `codec_regfile`

## Requirements
- R1: Reading the index port returns bit 7 = initialization busy, bit 6 = mode-change flag, bit 5 = 0, bits 4:0 = the stored index. After reset is released, bit 7 reads 1 for exactly INIT_CYCLES cycles, then reads 0 until the next reset.
- R2: A data-port write that arrives while initialization is busy leaves every register unchanged. Index-port writes are accepted at all times.
- R3: Registers without read-only bits (for example index 0 and index 3) read back exactly the byte last written.
- R4: Bit 4 of register 1 is read-only and always reads 0. Its other bits read back as written.
- R5: Register 12 reads bit 7 and bits 3:0 from the REV_ID parameter, and bits 5:4 as 0, whatever is written to them. Bit 6 is the writable mode-2 enable.
- R6: With mode-2 enable clear, index i+16 reaches the same storage as index i, for both reads and writes.
- R7: With mode-2 enable set, register 12 reads with bits 7 and 6 both 1. Indices 16 to 31 then reach storage of their own, so writing register 2 leaves register 18 unchanged.
- R8: An index-port write that clears the mode-change flag while the flag is set starts calibration. Bit 5 of register 9 then reads 1 for exactly CAL_CYCLES cycles and then reads 0. The other bits of register 9 are writable.
- R9: Each read strobe yields exactly one `bus_rvalid` pulse on the following cycle, carrying the data.
- R10: An index-port write with the mode-change flag 0, while the flag is already 0, does not start calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Port select: 0 index port, 1 data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle pulse the cycle after a read strobe |

## Verification
The bench aims at folding of indices 16 to 31. If a design decodes the full index in legacy mode, an alias read returns 0 instead of the lower register. If it folds in mode 2, writing register 2 corrupts register 18. The bench counts the exact length of the initialization and calibration windows. An off-by-one counter shows up there as one read too many or too few with the busy bit set. The bench also writes all ones to the revision register and to the volume register with the read-only bit. A design that stores those bits reads back a changed revision or a set bit 4. A design that accepts writes during initialization leaves a nonzero byte where 0 is expected.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int DW         = 8;
  localparam int IDX_W      = 5;
  localparam int NUM_REGS   = 1 << IDX_W;
  localparam int LEGACY_W   = IDX_W - 1;

  // register indices whose behaviour is special
  localparam int REG_VOL_R  = 1;
  localparam int REG_TEST   = 9;
  localparam int REG_MISC   = 12;

  // bit positions
  localparam int BIT_RO_VOL = 4;
  localparam int BIT_CAL    = 5;
  localparam int BIT_MODE2  = 6;
  localparam int BIT_BUSY   = 7;

  // writable-bit mask per register index
  function automatic logic [DW-1:0] wr_mask(input int idx);
    logic [DW-1:0] m;
    m = '1;
    if (idx == REG_VOL_R) m[BIT_RO_VOL] = 1'b0;
    if (idx == REG_TEST)  m[BIT_CAL]    = 1'b0;
    if (idx == REG_MISC)  m = DW'(1) << BIT_MODE2;
    return m;
  endfunction
endpackage

// File: rtl/cr_index_port.sv
module cr_index_port
  import codec_regs_pkg::*;
#(
  parameter int INIT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             mce_in,
  output logic [IDX_W-1:0] idx_q,
  output logic             mce_q,
  output logic             init_busy,
  output logic             cal_start
);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);

  logic [INIT_W-1:0] init_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_cnt <= INIT_W'(INIT_CYCLES);
    end else if (init_cnt != '0) begin
      init_cnt <= init_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      mce_q <= 1'b0;
    end else if (idx_we) begin
      idx_q <= idx_in;
      mce_q <= mce_in;
    end
  end

  assign init_busy = (init_cnt != '0);
  // leaving mode-change state kicks off calibration
  assign cal_start = idx_we && mce_q && !mce_in;
endmodule

// File: rtl/cr_cal_timer.sv
module cr_cal_timer #(
  parameter int CAL_CYCLES = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CAL_W = $clog2(CAL_CYCLES + 1);

  logic [CAL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CAL_W'(CAL_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cr_reg_array.sv
module cr_reg_array
  import codec_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             mode2
);
  logic [NUM_REGS-1:0][DW-1:0] bank;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = wr_mask(g);
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we && addr == IDX_W'(g)) begin
        q <= wdata & MASK;
      end
    end
    assign bank[g] = q;
  end

  assign rdata = bank[addr];
  assign mode2 = bank[REG_MISC][BIT_MODE2];
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
#(
  parameter int            INIT_CYCLES = 64,
  parameter int            CAL_CYCLES  = 384,
  parameter logic [DW-1:0] REV_ID      = 8'h0A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] eff_idx;
  logic             mce_q;
  logic             init_busy;
  logic             cal_start;
  logic             cal_busy;
  logic             mode2;
  logic             data_we;
  logic [DW-1:0]    raw_rd;
  logic [DW-1:0]    data_rd;
  logic [DW-1:0]    index_rd;

  cr_index_port #(.INIT_CYCLES(INIT_CYCLES)) u_index (
    .clk       (clk),
    .rst       (rst),
    .idx_we    (bus_wr && !bus_sel),
    .idx_in    (bus_wdata[IDX_W-1:0]),
    .mce_in    (bus_wdata[BIT_MODE2]),
    .idx_q     (idx_q),
    .mce_q     (mce_q),
    .init_busy (init_busy),
    .cal_start (cal_start)
  );

  cr_cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk   (clk),
    .rst   (rst),
    .start (cal_start),
    .busy  (cal_busy)
  );

  // legacy mode folds the upper half onto the lower half
  assign eff_idx = mode2 ? idx_q : {1'b0, idx_q[LEGACY_W-1:0]};
  assign data_we = bus_wr && bus_sel && !init_busy;

  cr_reg_array u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (data_we),
    .addr  (eff_idx),
    .wdata (bus_wdata),
    .rdata (raw_rd),
    .mode2 (mode2)
  );

  always_comb begin
    data_rd = raw_rd;
    if (eff_idx == IDX_W'(REG_TEST)) begin
      data_rd[BIT_CAL] = cal_busy;
    end else if (eff_idx == IDX_W'(REG_MISC)) begin
      data_rd            = REV_ID & 8'h8F;
      data_rd[BIT_MODE2] = mode2;
      data_rd[7]         = REV_ID[7] | mode2;
    end
  end

  always_comb begin
    index_rd              = '0;
    index_rd[IDX_W-1:0]   = idx_q;
    index_rd[BIT_MODE2]   = mce_q;
    index_rd[BIT_BUSY]    = init_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= bus_sel ? data_rd : index_rd;
    end
  end
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk
  import codec_regs_pkg::*;
#(
  parameter int CAL_CYCLES = 384
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_rvalid,
  input logic [IDX_W-1:0] idx_q,
  input logic             mode2,
  input logic             init_busy,
  input logic             cal_start,
  input logic             cal_busy
);
  localparam int RUN_W = $clog2(CAL_CYCLES + 2);
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || cal_start) run_cnt <= '0;
    else if (cal_busy)    run_cnt <= run_cnt + 1'b1;
  end

  p_busy_stays_low_r1: assert property (@(posedge clk) disable iff (rst)
    !init_busy |=> !init_busy);

  p_read_answers_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  p_cal_starts_r8: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> cal_busy);

  p_cal_window_r8: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && !cal_start) |-> (run_cnt < RUN_W'(CAL_CYCLES)));

  p_mode2_id_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel && mode2 && idx_q == IDX_W'(REG_MISC))
      |=> (bus_rdata[7:6] == 2'b11));

  p_ro_vol_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_sel && idx_q[LEGACY_W-1:0] == LEGACY_W'(REG_VOL_R)
      && !(mode2 && idx_q[IDX_W-1]))
      |=> !bus_rdata[BIT_RO_VOL]);
endmodule

bind codec_regfile codec_regfile_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .idx_q      (idx_q),
  .mode2      (mode2),
  .init_busy  (init_busy),
  .cal_start  (cal_start),
  .cal_busy   (cal_busy)
);

// File: tb/tb_codec_regfile.sv
module tb_codec_regfile;
  localparam int INIT_N = 8;
  localparam int CAL_N  = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  codec_regfile #(.INIT_CYCLES(INIT_N), .CAL_CYCLES(CAL_N), .REV_ID(8'h0A)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  // monitor: pops expected items as read data arrives
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9: unexpected rvalid, data %02h expected no response", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s: read %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    bus_wr = 0; bus_rd = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    bus_sel = sel; bus_wr = 1; bus_rd = 0; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] e, input string t);
    bus_sel = sel; bus_rd = 1; bus_wr = 0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: busy bit for exactly INIT_N reads, then clear
    for (int k = 0; k < INIT_N + 2; k++)
      rd(0, (k < INIT_N) ? 8'h80 : 8'h00, "R1");
    idle(3);

    // R2: data write during init is dropped
    do_reset();
    wr(0, 8'h03);
    wr(1, 8'h77);
    idle(INIT_N + 2);
    rd(0, 8'h03, "R1");
    rd(1, 8'h00, "R2");

    // R3: plain readback
    wr(1, 8'h77); rd(1, 8'h77, "R3");
    wr(0, 8'h00);
    wr(1, 8'h8A); rd(1, 8'h8A, "R3");
    wr(1, 8'h65); rd(1, 8'h65, "R3");

    // R4: read-only bit in register 1
    wr(0, 8'h01);
    wr(1, 8'h55); rd(1, 8'h45, "R4");
    wr(1, 8'hFF); rd(1, 8'hEF, "R4");

    // R5: revision code fixed
    wr(0, 8'h0C);
    rd(1, 8'h0A, "R5");
    wr(1, 8'hBF); rd(1, 8'h0A, "R5");

    // R6: legacy aliasing
    wr(0, 8'h10);
    wr(1, 8'h3C);
    wr(0, 8'h00); rd(1, 8'h3C, "R6");
    wr(0, 8'h13); rd(1, 8'h77, "R6");
    wr(0, 8'h1C); rd(1, 8'h0A, "R6");

    // R7: mode 2 widens the space
    wr(0, 8'h0C);
    wr(1, 8'h40); rd(1, 8'hCA, "R7");
    wr(0, 8'h12); wr(1, 8'h88);
    wr(0, 8'h02); wr(1, 8'h45);
    wr(0, 8'h12); rd(1, 8'h88, "R7");
    wr(0, 8'h02); rd(1, 8'h45, "R7");
    wr(0, 8'h10); rd(1, 8'h00, "R7");
    wr(0, 8'h1C); rd(1, 8'h00, "R7");
    wr(0, 8'h0C); wr(1, 8'h00); rd(1, 8'h0A, "R5");
    wr(0, 8'h12); rd(1, 8'h45, "R6");

    // R8: calibration window
    wr(0, 8'h09);
    wr(1, 8'h2F); rd(1, 8'h0F, "R8");
    wr(0, 8'h49); rd(0, 8'h49, "R1");
    wr(0, 8'h09);
    for (int k = 0; k < CAL_N + 1; k++)
      rd(1, (k < CAL_N) ? 8'h2F : 8'h0F, "R8");

    // R10: no start without a set flag
    wr(0, 8'h09);
    rd(1, 8'h0F, "R10");
    idle(3);

    // R9: single-cycle response pulse
    rd(1, 8'h0F, "R9");
    tests++;
    if (bus_rvalid !== 1'b1) begin
      fails++; $display("FAIL R9: rvalid %b expected 1", bus_rvalid);
    end
    @(negedge clk);
    tests++;
    if (bus_rvalid !== 1'b0) begin
      fails++; $display("FAIL R9: rvalid %b expected 0", bus_rvalid);
    end
    idle(3);

    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule